// File: doc/BRIEF.md
# Big-Number Operand Packer

This block takes one operand of a modular exponentiation (exponent or modulus) as a byte stream, most significant byte first. Bytes arrive over a valid/ready handshake, and a last flag marks the final byte. Zero bytes at the head of the operand are dropped as they arrive. The block captures the leading-zero count of the first nonzero byte and uses it to report the exact number of significant bits. The significant bytes are gathered into 32-bit words in an internal word store.

Once the final byte is in, the block sends the words out over a second valid/ready stream, least significant word first. Each word carries its logical word index, so a downstream mapper can place it in engine memory. The most significant word is filled from its low end, so when the byte count is not a multiple of four its unused upper bytes are zero. The block also keeps a packed key-length value that holds the last exponent and modulus bit lengths side by side.

An operand whose total byte count, leading zeros included, exceeds the configured maximum (512 bytes by default) is rejected. It then produces no words and does not change the key-length value.

Top module: `opnd_pack`

## Requirements
- R1: Zero bytes that come before the first nonzero byte are discarded and count neither toward the bit length, the word count nor any emitted word.
- R2: `bit_len_o` equals eight times the significant byte count minus the number of leading zero bits in the first significant byte; an operand of only zero bytes reports 0, emits no words and still completes.
- R3: `word_cnt_o` equals the significant byte count divided by four, rounded up.
- R4: Words are emitted least significant first with `out_idx_o` counting 0, 1, 2 and so on, and `out_last_o` is high only on the word with index `word_cnt_o - 1`.
- R5: Inside a word, a byte that arrived earlier sits at a higher bit position (bits 31:24 hold the earliest of four bytes); when the significant byte count is not a multiple of four, the most significant word holds the leftover bytes in its low bytes and zeros above.
- R6: When more than MAX_BYTES bytes (512 by default, leading zeros included) arrive before the last flag, completion reports `err_o` = 1, `bit_len_o` = 0 and `word_cnt_o` = 0, and no word is emitted; exactly MAX_BYTES bytes are accepted without error.
- R7: `op_kind_i` is sampled with the first byte of an operand (0 = exponent, 1 = modulus). On error-free completion, the bit length is written to `keylen_o[31:16]` for an exponent or to `keylen_o[15:0]` for a modulus, and the other half is kept; an operand that ends in error leaves `keylen_o` unchanged.
- R8: `in_ready_o` goes low in the cycle after the final byte is accepted and stays low until after `done_o`. `done_o` is a single-cycle pulse that follows the last word handshake, or follows the closing cycle when there are no words. The results are valid while `done_o` is high.
- R9: While `out_valid_o` is high and `out_ready_i` is low, `out_data_o`, `out_idx_o` and `out_last_o` hold their values into the next cycle.
- R10: After reset `in_ready_o` is 1, and `out_valid_o`, `done_o`, `err_o`, `bit_len_o`, `word_cnt_o` and `keylen_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block accepts an input byte |
| in_data_i | input | 8 | Operand byte, most significant first |
| in_last_i | input | 1 | Marks the final byte of the operand |
| op_kind_i | input | 1 | Operand kind: 0 exponent, 1 modulus (sampled on the first byte) |
| out_valid_o | output | 1 | Output word valid |
| out_ready_i | input | 1 | Consumer accepts the output word |
| out_data_o | output | 32 | Packed operand word |
| out_idx_o | output | 7 | Logical word index, 0 = least significant |
| out_last_o | output | 1 | Final word of the operand |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Operand rejected for length |
| bit_len_o | output | 16 | Significant bit length |
| word_cnt_o | output | 8 | Number of words emitted |
| keylen_o | output | 32 | Exponent bit length in [31:16], modulus bit length in [15:0] |

## Verification
Two pairs of events can happen on the same beat. In the first, the byte that crosses the length limit also carries the last flag, so error detection and operand closing happen together. This is provoked with operands of exactly 512 and 513 bytes, including one whose extra byte is a leading zero; it is judged by the error flag, the zero counts, the absence of words and an unchanged key-length value. In the second, a single-byte operand captures the leading-zero count, writes a partial word and closes the operand on one beat; it is judged by the bit length and by the right-aligned word. Runs of random operands with random input gaps and random output stalls check the word order and placement against a queue of expected words.

// File: rtl/opnd_pack_pkg.sv
package opnd_pack_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_CLOSE,
    ST_EMIT,
    ST_DONE
  } pk_state_e;

  // Leading zero bits of a nonzero byte.
  function automatic logic [2:0] lead_zeros8(input logic [7:0] b);
    logic [2:0] n;
    n = 3'd7;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) n = 3'(7 - i);
    end
    return n;
  endfunction

endpackage

// File: rtl/opnd_scan.sv
module opnd_scan
  import opnd_pack_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 512,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned ADDR_W    = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              beat_i,
  input  logic [7:0]        byte_i,
  input  logic              last_i,
  input  logic              kind_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [WORD_W-1:0] wdata_o,
  output logic [CNT_W-1:0]  sig_cnt_o,
  output logic [2:0]        nlz_o,
  output logic              err_o,
  output logic              kind_o
);

  logic [CNT_W-1:0] tot_q, sig_q;
  logic             seen_q, err_q, kind_q;
  logic [2:0]       nlz_q;
  logic [23:0]      acc_q;

  logic        sig_byte, over, err_nxt, keep;
  logic [1:0]  pos;
  logic [31:0] acc_full;

  always_comb begin
    sig_byte = seen_q || (byte_i != 8'd0);
    over     = (tot_q == CNT_W'(MAX_BYTES));
    err_nxt  = err_q || over;
    keep     = beat_i && sig_byte && !err_nxt;
    pos      = sig_q[1:0];
    acc_full = (pos == 2'd0) ? {24'd0, byte_i} : {acc_q, byte_i};
    we_o     = keep && ((pos == 2'd3) || last_i);
    waddr_o  = sig_q[ADDR_W+1:2];
    // left-align a partial group; emit side realigns it
    wdata_o  = acc_full << {(2'd3 - pos), 3'b000};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q  <= '0;
      sig_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= 1'b0;
      nlz_q  <= 3'd0;
      acc_q  <= 24'd0;
    end else if (clr_i) begin
      tot_q  <= '0;
      sig_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
      nlz_q  <= 3'd0;
      acc_q  <= 24'd0;
    end else if (beat_i) begin
      if (tot_q == '0) kind_q <= kind_i;
      if (!over) tot_q <= tot_q + 1'b1;
      else       err_q <= 1'b1;
      if (keep) begin
        sig_q <= sig_q + 1'b1;
        acc_q <= acc_full[23:0];
        if (!seen_q) begin
          seen_q <= 1'b1;
          nlz_q  <= lead_zeros8(byte_i);
        end
      end
    end
  end

  assign sig_cnt_o = sig_q;
  assign nlz_o     = nlz_q;
  assign err_o     = err_q;
  assign kind_o    = kind_q;

endmodule

// File: rtl/opnd_store.sv
module opnd_store
  import opnd_pack_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [WORD_W-1:0] rdata_a_o,
  output logic [WORD_W-1:0] rdata_b_o
);

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

endmodule

// File: rtl/opnd_emit.sv
module opnd_emit
  import opnd_pack_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned WCNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WCNT_W-1:0] wcnt_i,
  input  logic [1:0]        shift_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [WORD_W-1:0] lo_i,
  input  logic              out_ready_i,
  output logic [ADDR_W-1:0] raddr_hi_o,
  output logic [ADDR_W-1:0] raddr_lo_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic [ADDR_W-1:0] out_idx_o,
  output logic              out_last_o,
  output logic              fin_o
);

  logic              busy_q;
  logic [ADDR_W-1:0] k_q;
  logic [WCNT_W-1:0] top_idx;
  logic              has_lo;
  logic [2*WORD_W-1:0] win;

  always_comb begin
    top_idx    = wcnt_i - WCNT_W'(1) - WCNT_W'(k_q);
    has_lo     = (top_idx != '0);
    raddr_hi_o = top_idx[ADDR_W-1:0];
    raddr_lo_o = raddr_hi_o - 1'b1;
    win        = {has_lo ? lo_i : {WORD_W{1'b0}}, hi_i};
  end

  // byte lanes pick from the two-word window at the residue offset
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [5:0] base;
    assign base = 6'(8 * g) + {1'b0, shift_i, 3'b000};
    assign out_data_o[8*g +: 8] = win[base +: 8];
  end

  assign out_valid_o = busy_q;
  assign out_idx_o   = k_q;
  assign out_last_o  = busy_q && (WCNT_W'(k_q) == (wcnt_i - WCNT_W'(1)));
  assign fin_o       = busy_q && out_ready_i && out_last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      k_q    <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      k_q    <= '0;
    end else if (busy_q && out_ready_i) begin
      if (out_last_o) busy_q <= 1'b0;
      else            k_q    <= k_q + 1'b1;
    end
  end

endmodule

// File: rtl/opnd_pack.sv
module opnd_pack
  import opnd_pack_pkg::*;
#(
  parameter  int unsigned MAX_BYTES = 512,
  parameter  int unsigned LEN_W     = 16,
  localparam int unsigned DEPTH     = MAX_BYTES / WORD_BYTES,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned WCNT_W    = $clog2(DEPTH + 1),
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [7:0]         in_data_i,
  input  logic               in_last_i,
  input  logic               op_kind_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [WORD_W-1:0]  out_data_o,
  output logic [IDX_W-1:0]   out_idx_o,
  output logic               out_last_o,
  output logic               done_o,
  output logic               err_o,
  output logic [LEN_W-1:0]   bit_len_o,
  output logic [WCNT_W-1:0]  word_cnt_o,
  output logic [2*LEN_W-1:0] keylen_o
);

  pk_state_e st_q, st_d;

  logic              beat, scan_clr, scan_err, scan_kind, we, fin, start, no_words;
  logic [IDX_W-1:0]  waddr, raddr_hi, raddr_lo;
  logic [WORD_W-1:0] wdata, rd_hi, rd_lo;
  logic [CNT_W-1:0]  sig_cnt, sig_rnd;
  logic [2:0]        nlz;
  logic [WCNT_W-1:0] wcnt;
  logic [1:0]        shift;
  logic [LEN_W-1:0]  bits;

  logic               err_q;
  logic [LEN_W-1:0]   bit_len_q;
  logic [WCNT_W-1:0]  word_cnt_q;
  logic [2*LEN_W-1:0] keylen_q;

  assign in_ready_o = (st_q == ST_COLLECT);
  assign beat       = in_valid_i && in_ready_o;
  assign scan_clr   = (st_q == ST_DONE);
  assign done_o     = (st_q == ST_DONE);

  opnd_scan #(
    .MAX_BYTES(MAX_BYTES),
    .CNT_W    (CNT_W),
    .ADDR_W   (IDX_W)
  ) u_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (scan_clr),
    .beat_i   (beat),
    .byte_i   (in_data_i),
    .last_i   (in_last_i),
    .kind_i   (op_kind_i),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .sig_cnt_o(sig_cnt),
    .nlz_o    (nlz),
    .err_o    (scan_err),
    .kind_o   (scan_kind)
  );

  opnd_store #(
    .DEPTH (DEPTH),
    .ADDR_W(IDX_W)
  ) u_store (
    .clk_i    (clk_i),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .raddr_a_i(raddr_hi),
    .raddr_b_i(raddr_lo),
    .rdata_a_o(rd_hi),
    .rdata_b_o(rd_lo)
  );

  always_comb begin
    sig_rnd  = sig_cnt + CNT_W'(3);
    wcnt     = WCNT_W'(sig_rnd >> 2);
    shift    = 2'd0 - sig_cnt[1:0];
    bits     = LEN_W'({sig_cnt, 3'b000}) - LEN_W'(nlz);
    no_words = scan_err || (wcnt == '0);
    start    = (st_q == ST_CLOSE) && !no_words;
  end

  opnd_emit #(
    .ADDR_W(IDX_W),
    .WCNT_W(WCNT_W)
  ) u_emit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .wcnt_i     (wcnt),
    .shift_i    (shift),
    .hi_i       (rd_hi),
    .lo_i       (rd_lo),
    .out_ready_i(out_ready_i),
    .raddr_hi_o (raddr_hi),
    .raddr_lo_o (raddr_lo),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .out_idx_o  (out_idx_o),
    .out_last_o (out_last_o),
    .fin_o      (fin)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_COLLECT: if (beat && in_last_i) st_d = ST_CLOSE;
      ST_CLOSE:   st_d = no_words ? ST_DONE : ST_EMIT;
      ST_EMIT:    if (fin) st_d = ST_DONE;
      ST_DONE:    st_d = ST_COLLECT;
      default:    st_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_COLLECT;
      err_q      <= 1'b0;
      bit_len_q  <= '0;
      word_cnt_q <= '0;
      keylen_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_CLOSE) begin
        err_q      <= scan_err;
        bit_len_q  <= scan_err ? '0 : bits;
        word_cnt_q <= scan_err ? '0 : wcnt;
        if (!scan_err) begin
          if (scan_kind) keylen_q[LEN_W-1:0]       <= bits;
          else           keylen_q[2*LEN_W-1:LEN_W] <= bits;
        end
      end
    end
  end

  assign err_o      = err_q;
  assign bit_len_o  = bit_len_q;
  assign word_cnt_o = word_cnt_q;
  assign keylen_o   = keylen_q;

endmodule

// File: rtl/opnd_pack_chk.sv
module opnd_pack_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned WCNT_W = 8,
  parameter int unsigned LEN_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [31:0]       out_data_o,
  input logic [IDX_W-1:0]  out_idx_o,
  input logic              out_last_o,
  input logic              done_o,
  input logic              err_o,
  input logic [LEN_W-1:0]  bit_len_o,
  input logic [WCNT_W-1:0] word_cnt_o
);

  // R9
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_idx_o) && $stable(out_last_o));

  // R4
  first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> out_idx_o == '0);

  // R4
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=>
      out_valid_o && out_idx_o == $past(out_idx_o) + 1'b1);

  // R4
  last_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && in_ready_o);

  // R8
  in_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && (out_valid_o || done_o)));

  // R3
  cnt_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> 17'(word_cnt_o) == ((17'(bit_len_o) + 17'd31) >> 5));

  // R6
  err_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> word_cnt_o == '0 && bit_len_o == '0);

endmodule

bind opnd_pack opnd_pack_chk #(
  .IDX_W (IDX_W),
  .WCNT_W(WCNT_W),
  .LEN_W (LEN_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .out_data_o (out_data_o),
  .out_idx_o  (out_idx_o),
  .out_last_o (out_last_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .bit_len_o  (bit_len_o),
  .word_cnt_o (word_cnt_o)
);

// File: tb/opnd_pack_tb.sv
`timescale 1ns/1ps
module opnd_pack_tb;

  localparam int MAXB = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic [7:0]  in_data_i = 8'd0;
  logic        in_last_i = 1'b0;
  logic        op_kind_i = 1'b0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] out_data_o;
  logic [6:0]  out_idx_o;
  logic        out_last_o;
  logic        done_o, err_o;
  logic [15:0] bit_len_o;
  logic [7:0]  word_cnt_o;
  logic [31:0] keylen_o;

  always #2 clk_i = ~clk_i;

  opnd_pack u_dut (.*);

  typedef struct { logic [31:0] d; logic [6:0] i; logic l; } wexp_t;
  typedef struct { logic [15:0] b; logic [7:0] c; logic e; logic [31:0] k; } rexp_t;

  wexp_t       wq[$];
  rexp_t       rq[$];
  logic [7:0]  op[$];
  logic [31:0] kl_model = 32'd0;
  int          n_chk = 0, n_err = 0;
  bit          bp_en = 1'b0;
  int          gap = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  function automatic int clz8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) if (b[i]) return 7 - i;
    return 8;
  endfunction

  // output stall pattern, changed away from the sampling edge
  always begin
    @(posedge clk_i);
    #1;
    out_ready_i = bp_en ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (out_valid_o && out_ready_i) begin
        if (wq.size() == 0) chk(1'b0, "R4 unexpected word", {25'd0, out_idx_o}, 64'd0);
        else begin
          wexp_t w;
          w = wq.pop_front();
          chk(out_data_o == w.d, "R5 word data", out_data_o, w.d);
          chk(out_idx_o == w.i && out_last_o == w.l, "R4 index/last",
              {out_idx_o, out_last_o}, {w.i, w.l});
        end
      end
      if (done_o) begin
        chk(wq.size() == 0, "R4 words missing at done", wq.size(), 0);
        if (rq.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
          rexp_t r;
          r = rq.pop_front();
          chk(bit_len_o == r.b, "R2 bit length", bit_len_o, r.b);
          chk(word_cnt_o == r.c, "R3 word count", word_cnt_o, r.c);
          chk(err_o == r.e, "R6 error flag", err_o, r.e);
          chk(keylen_o == r.k, "R7 key length", keylen_o, r.k);
        end
      end
    end
  end

  task automatic send_op(input bit kind);
    int n, f, sig, s, i;
    rexp_t r;
    while (rq.size() != 0) @(negedge clk_i);
    n = op.size();
    f = 0;
    while (f < n && op[f] == 8'd0) f++;
    sig = n - f;
    if (n > MAXB) begin
      r.b = 16'd0; r.c = 8'd0; r.e = 1'b1; r.k = kl_model;
    end else begin
      r.b = (sig == 0) ? 16'd0 : 16'(sig * 8 - clz8(op[f]));
      s = (sig + 3) / 4;
      r.c = 8'(s);
      r.e = 1'b0;
      for (int k = 0; k < s; k++) begin
        wexp_t w;
        w.d = 32'd0;
        for (int b = 0; b < 4; b++) begin
          int p;
          p = n - 1 - (4 * k + b);
          if (p >= f) w.d[8*b +: 8] = op[p];
        end
        w.i = 7'(k);
        w.l = (k == s - 1);
        wq.push_back(w);
      end
      if (kind) kl_model[15:0] = r.b;
      else      kl_model[31:16] = r.b;
      r.k = kl_model;
    end
    rq.push_back(r);
    i = 0;
    while (i < n) begin
      @(negedge clk_i);
      if (in_ready_o && ($urandom_range(0, 99) >= gap)) begin
        in_valid_i = 1'b1;
        in_data_i  = op[i];
        in_last_i  = (i == n - 1);
        op_kind_i  = kind;
        i++;
      end else begin
        in_valid_i = 1'b0;
      end
    end
    @(negedge clk_i);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
    chk(in_ready_o == 1'b0, "R8 input closed after last", in_ready_o, 0);
  endtask

  task automatic fill(input int lz, input int nsig, input int top);
    op.delete();
    for (int j = 0; j < lz; j++) op.push_back(8'd0);
    for (int j = 0; j < nsig; j++) begin
      if (j == 0 && top >= 0) op.push_back(8'(top));
      else op.push_back(8'($urandom_range(0, 255)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10
    chk(in_ready_o == 1'b1, "R10 ready after reset", in_ready_o, 1);
    chk(!out_valid_o && !done_o && !err_o, "R10 outputs idle", {out_valid_o, done_o, err_o}, 0);
    chk(bit_len_o == 0 && word_cnt_o == 0 && keylen_o == 0, "R10 results zero",
        {bit_len_o, word_cnt_o, keylen_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // R2 R5: single byte, first significant byte closes a partial word
    op.delete(); op.push_back(8'h01);
    send_op(1'b1);
    // R1: leading zeros dropped, 21 bits
    op.delete(); op = '{8'h00, 8'h00, 8'h12, 8'h34, 8'h56};
    send_op(1'b0);
    // R5: partial top word right-aligned
    op.delete(); op = '{8'h80, 8'h11, 8'h22, 8'h33, 8'h44};
    send_op(1'b1);
    // R3: exact multiple of four
    op.delete(); op = '{8'h0f, 8'hee, 8'hdd, 8'hcc, 8'hbb, 8'haa, 8'h99, 8'h88};
    send_op(1'b0);
    // R2: all zero operand
    op.delete(); op = '{8'h00, 8'h00, 8'h00, 8'h00};
    send_op(1'b1);
    // R6 boundary: exactly the maximum
    fill(0, MAXB, 8'h80);
    send_op(1'b1);
    // R6 R7: one byte over, key length untouched
    fill(0, MAXB + 1, 8'h7f);
    send_op(1'b0);
    // R6: the extra byte is a leading zero
    fill(1, MAXB, 8'h80);
    send_op(1'b1);

    // R9: random operands under output stalls and input gaps
    bp_en = 1'b1;
    gap = 30;
    for (int t = 0; t < 12; t++) begin
      fill($urandom_range(0, 3), $urandom_range(1, 40), $urandom_range(0, 1) ? -1 : 1);
      send_op(t[0]);
    end
    while (rq.size() != 0) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk(wq.size() == 0, "R4 queue drained", wq.size(), 0);
    summary();
  end

endmodule